// File: doc/BRIEF.md
# AGC Gain-Error Update Loop

This block holds the gain word of a digital automatic gain control loop and updates it from a stream of signed gain-error samples. For each accepted sample it picks one of two programmable loop gains and turns the error into a signed step. It adds that step to a 16-bit unsigned gain word. The adder saturates at both ends and never wraps. The gain word drives the multiplier that applies the gain, which lies outside this block.

There are two settling modes. In proportional (mean) mode the error is arithmetically right-shifted by the loop gain and the whole result is added, so the gain closes in on its target asymptotically. In fixed-step sign (median) mode only the sign of the error matters, and the gain moves by one LSB shifted left by the loop gain. This settles faster and in a fixed time, but leaves more ripple.

The loop gain is chosen from three sources. A host select bit forces loop gain 1 and overrides everything else. With that bit clear, an enable bit can hand the choice to a tag carried with each error sample from the upstream filter engine. With both clear, loop gain 0 is used. Error samples arrive on a valid/ready interface. The block never applies back-pressure: `err_ready` is always high, and a sample is consumed in every cycle where `err_valid` is high. Configuration pins are plain levels and are sampled together with each accepted error.

Top module: `agc_loop`

## Requirements
- R1: While `rst` is high at a rising clock edge, `gain_out` loads `cfg_init_gain` on that edge.
- R2: When `cfg_host_sel` is 1, the active loop gain is `cfg_gain1`, whatever the values of `cfg_fe_en` and `err_tag`.
- R3: When `cfg_host_sel` and `cfg_fe_en` are both 0, the active loop gain is `cfg_gain0`, and `err_tag` has no effect.
- R4: When `cfg_host_sel` is 0 and `cfg_fe_en` is 1, `err_tag` = 0 selects `cfg_gain0` and `err_tag` = 1 selects `cfg_gain1`.
- R5: In mean mode (`cfg_median` = 0), an accepted sample adds `err_data` arithmetically right-shifted by the active loop gain, rounded toward minus infinity (so an error of -1 always gives a step of -1).
- R6: In median mode (`cfg_median` = 1), an accepted sample adds +2^k for a positive error, -2^k for a negative error and 0 for a zero error, where k is the active loop gain.
- R7: The updated gain saturates to 0 when the sum is below 0 and to 65535 when it is above 65535. It never wraps.
- R8: `gain_out` changes only on a rising edge where `err_valid` is 1 (or `rst` is 1). The result appears on `gain_out` right after that edge.
- R9: `err_ready` is 1 in every cycle, so the block never stalls the error stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_init_gain | input | 16 | Gain word loaded during reset |
| cfg_gain0 | input | 4 | Loop gain 0, a right-shift amount |
| cfg_gain1 | input | 4 | Loop gain 1, a right-shift amount |
| cfg_host_sel | input | 1 | Host loop-gain select; 1 forces loop gain 1 |
| cfg_fe_en | input | 1 | Lets the per-sample tag choose the loop gain |
| cfg_median | input | 1 | Settling mode: 0 mean, 1 median |
| err_valid | input | 1 | Error sample valid |
| err_ready | output | 1 | Always 1; the block accepts every sample |
| err_data | input | 16 | Signed gain-error sample |
| err_tag | input | 1 | Loop-gain select carried with the sample |
| gain_out | output | 16 | Current gain word |

## Verification
The hardest states to reach are the saturation rails. Random errors make the gain wander near mid-scale, and only long runs of same-sign errors at small shifts push it to 0 or 65535. The bench therefore starts directed sequences from an initial gain a few LSBs from each rail, with shift 0 and errors large enough to overshoot. It also biases part of the random phase toward small shifts and same-sign errors. The gain-select priority is visible only when the two loop gains differ, so those directed cases use distinct shifts and an error whose scaled value is different for each shift.

// File: rtl/agc_loop_pkg.sv
package agc_loop_pkg;

  typedef enum logic {
    SETTLE_MEAN   = 1'b0,
    SETTLE_MEDIAN = 1'b1
  } settle_mode_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/agc_gain_select.sv
module agc_gain_select #(
  parameter int SHIFT_W = 4
) (
  input  logic               host_sel,
  input  logic               fe_en,
  input  logic               tag,
  input  logic [SHIFT_W-1:0] gain0,
  input  logic [SHIFT_W-1:0] gain1,
  output logic [SHIFT_W-1:0] shift
);

  // Priority: host override, then filter-engine tag, then default gain 0.
  always_comb begin
    if (host_sel)       shift = gain1;
    else if (fe_en)     shift = tag ? gain1 : gain0;
    else                shift = gain0;
  end

endmodule

// File: rtl/agc_step_calc.sv
module agc_step_calc
  import agc_loop_pkg::*;
#(
  parameter int ERR_W   = 16,
  parameter int SHIFT_W = 4,
  parameter int DELTA_W = 17
) (
  input  logic signed [ERR_W-1:0]   err,
  input  logic        [SHIFT_W-1:0] shift,
  input  settle_mode_e              mode,
  output logic signed [DELTA_W-1:0] delta
);

  localparam int EXT_W = DELTA_W - ERR_W;

  logic signed [DELTA_W-1:0] err_ext;
  logic signed [DELTA_W-1:0] mean_step;
  logic signed [DELTA_W-1:0] unit_step;

  assign err_ext   = {{EXT_W{err[ERR_W-1]}}, err};
  assign mean_step = err_ext >>> shift;
  assign unit_step = {{(DELTA_W-1){1'b0}}, 1'b1} << shift;

  always_comb begin
    if (mode == SETTLE_MEDIAN) begin
      if (err == '0)            delta = '0;
      else if (err[ERR_W-1])    delta = -unit_step;
      else                      delta = unit_step;
    end else begin
      delta = mean_step;
    end
  end

endmodule

// File: rtl/agc_accum.sv
module agc_accum
  import agc_loop_pkg::*;
#(
  parameter int GAIN_W  = 16,
  parameter int DELTA_W = 17
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic        [GAIN_W-1:0]  init_gain,
  input  logic                      upd_en,
  input  logic signed [DELTA_W-1:0] delta,
  output logic        [GAIN_W-1:0]  gain
);

  localparam int SUM_W = max_int(GAIN_W, DELTA_W) + 2;
  localparam logic signed [SUM_W-1:0] TOP_S =
    {{(SUM_W-GAIN_W){1'b0}}, {GAIN_W{1'b1}}};

  logic signed [SUM_W-1:0] gain_s;
  logic signed [SUM_W-1:0] delta_s;
  logic signed [SUM_W-1:0] sum_s;
  logic        [GAIN_W-1:0] gain_nxt;

  assign gain_s  = {{(SUM_W-GAIN_W){1'b0}}, gain};
  assign delta_s = {{(SUM_W-DELTA_W){delta[DELTA_W-1]}}, delta};
  assign sum_s   = gain_s + delta_s;

  always_comb begin
    if (sum_s < 0)          gain_nxt = '0;
    else if (sum_s > TOP_S) gain_nxt = '1;
    else                    gain_nxt = sum_s[GAIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)         gain <= init_gain;
    else if (upd_en) gain <= gain_nxt;
  end

  assert_reset_load_R1: assert property (@(posedge clk)
    rst |=> gain == $past(init_gain));

  assert_pos_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (upd_en && delta > 0) |=> gain >= $past(gain));

  assert_neg_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (upd_en && delta < 0) |=> gain <= $past(gain));

endmodule

// File: rtl/agc_loop.sv
module agc_loop
  import agc_loop_pkg::*;
#(
  parameter int ERR_W   = 16,
  parameter int GAIN_W  = 16,
  parameter int SHIFT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [GAIN_W-1:0]       cfg_init_gain,
  input  logic [SHIFT_W-1:0]      cfg_gain0,
  input  logic [SHIFT_W-1:0]      cfg_gain1,
  input  logic                    cfg_host_sel,
  input  logic                    cfg_fe_en,
  input  logic                    cfg_median,
  input  logic                    err_valid,
  output logic                    err_ready,
  input  logic signed [ERR_W-1:0] err_data,
  input  logic                    err_tag,
  output logic [GAIN_W-1:0]       gain_out
);

  localparam int DELTA_W = max_int(ERR_W, 1 << SHIFT_W) + 1;

  logic [SHIFT_W-1:0]        act_shift;
  logic signed [DELTA_W-1:0] step;
  settle_mode_e              mode;
  logic                      accept;

  assign err_ready = 1'b1;
  assign accept    = err_valid && err_ready;
  assign mode      = settle_mode_e'(cfg_median);

  agc_gain_select #(.SHIFT_W(SHIFT_W)) u_sel (
    .host_sel (cfg_host_sel),
    .fe_en    (cfg_fe_en),
    .tag      (err_tag),
    .gain0    (cfg_gain0),
    .gain1    (cfg_gain1),
    .shift    (act_shift)
  );

  agc_step_calc #(.ERR_W(ERR_W), .SHIFT_W(SHIFT_W), .DELTA_W(DELTA_W)) u_step (
    .err   (err_data),
    .shift (act_shift),
    .mode  (mode),
    .delta (step)
  );

  agc_accum #(.GAIN_W(GAIN_W), .DELTA_W(DELTA_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .init_gain (cfg_init_gain),
    .upd_en    (accept),
    .delta     (step),
    .gain      (gain_out)
  );

  assert_host_override_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_host_sel |-> act_shift == cfg_gain1);

  assert_default_gain0_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_host_sel && !cfg_fe_en) |-> act_shift == cfg_gain0);

  assert_median_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (err_valid && cfg_median && err_data == '0) |=> $stable(gain_out));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !err_valid |=> $stable(gain_out));

  assert_always_ready_R9: assert property (@(posedge clk) disable iff (rst)
    err_ready);

endmodule

// File: tb/agc_loop_tb_top.sv
module agc_loop_tb_top;

  logic               clk = 1'b0;
  logic               rst;
  logic [15:0]        cfg_init_gain;
  logic [3:0]         cfg_gain0, cfg_gain1;
  logic               cfg_host_sel, cfg_fe_en, cfg_median;
  logic               err_valid;
  logic               err_ready;
  logic signed [15:0] err_data;
  logic               err_tag;
  logic [15:0]        gain_out;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_gain;
  bit done = 1'b0;

  always #2 clk = ~clk;

  agc_loop dut_i (
    .clk(clk), .rst(rst), .cfg_init_gain(cfg_init_gain),
    .cfg_gain0(cfg_gain0), .cfg_gain1(cfg_gain1),
    .cfg_host_sel(cfg_host_sel), .cfg_fe_en(cfg_fe_en),
    .cfg_median(cfg_median), .err_valid(err_valid), .err_ready(err_ready),
    .err_data(err_data), .err_tag(err_tag), .gain_out(gain_out)
  );

  function automatic logic [3:0] pick_shift(input logic host, input logic fe,
                                            input logic tag, input logic [3:0] g0,
                                            input logic [3:0] g1);
    if (host) return g1;
    if (fe && tag) return g1;
    return g0;
  endfunction

  function automatic logic [15:0] next_gain(input logic [15:0] g,
                                            input logic signed [15:0] e,
                                            input logic [3:0] sh,
                                            input logic med);
    longint d;
    longint s;
    if (med) d = (e > 0) ? (longint'(1) << sh) : (e < 0) ? -(longint'(1) << sh) : 0;
    else     d = longint'(e) >>> sh;
    s = longint'(g) + d;
    if (s < 0) s = 0;
    if (s > 65535) s = 65535;
    return 16'(s);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [15:0] init);
    @(negedge clk);
    rst = 1'b1; cfg_init_gain = init; err_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    exp_gain = init;
    check("R1", gain_out, init);
  endtask

  task automatic step(input string req, input logic v, input logic signed [15:0] e,
                      input logic tag);
    logic [3:0] sh;
    @(negedge clk);
    err_valid = v; err_data = e; err_tag = tag;
    check("R9", {15'd0, err_ready}, 16'd1);
    sh = pick_shift(cfg_host_sel, cfg_fe_en, tag, cfg_gain0, cfg_gain1);
    if (v) exp_gain = next_gain(exp_gain, e, sh, cfg_median);
    @(posedge clk);
    #1;
    check(req, gain_out, exp_gain);
    err_valid = 1'b0;
  endtask

  task automatic cfg(input logic host, input logic fe, input logic med,
                     input logic [3:0] g0, input logic [3:0] g1);
    cfg_host_sel = host; cfg_fe_en = fe; cfg_median = med;
    cfg_gain0 = g0; cfg_gain1 = g1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; err_valid = 1'b0; err_data = '0; err_tag = 1'b0;
    cfg_init_gain = 16'd1000;
    cfg(1'b0, 1'b0, 1'b0, 4'd0, 4'd0);
    repeat (2) @(negedge clk);
    do_reset(16'd30000);

    // R2: host override beats tag 0 and enable
    cfg(1'b1, 1'b1, 1'b0, 4'd0, 4'd4);
    step("R2", 1'b1, 16'sd160, 1'b0);
    // R3: default gain 0, tag ignored
    cfg(1'b0, 1'b0, 1'b0, 4'd2, 4'd6);
    step("R3", 1'b1, 16'sd64, 1'b1);
    // R4: tag picks gain
    cfg(1'b0, 1'b1, 1'b0, 4'd2, 4'd6);
    step("R4", 1'b1, 16'sd64, 1'b1);
    step("R4", 1'b1, 16'sd64, 1'b0);
    // R5: floor rounding of negative errors
    cfg(1'b0, 1'b0, 1'b0, 4'd4, 4'd4);
    step("R5", 1'b1, -16'sd1, 1'b0);
    step("R5", 1'b1, -16'sd100, 1'b0);
    step("R5", 1'b1, 16'sd15, 1'b0);
    // R6: median steps
    cfg(1'b0, 1'b0, 1'b1, 4'd3, 4'd9);
    step("R6", 1'b1, 16'sd0, 1'b0);
    step("R6", 1'b1, -16'sd3, 1'b0);
    step("R6", 1'b1, 16'sd32767, 1'b0);
    // R8: idle does not update
    step("R8", 1'b0, 16'sd20000, 1'b1);
    step("R8", 1'b0, -16'sd20000, 1'b0);
    // R7: saturation at both rails
    do_reset(16'd65530);
    cfg(1'b0, 1'b0, 1'b0, 4'd0, 4'd0);
    step("R7", 1'b1, 16'sd100, 1'b0);
    step("R7", 1'b1, 16'sd32767, 1'b0);
    do_reset(16'd5);
    step("R7", 1'b1, -16'sd100, 1'b0);
    step("R7", 1'b1, -16'sd32768, 1'b0);
    cfg(1'b0, 1'b0, 1'b1, 4'd15, 4'd15);
    step("R7", 1'b1, -16'sd1, 1'b0);
    do_reset(16'd65000);
    step("R7", 1'b1, 16'sd1, 1'b0);

    // Random phase
    do_reset(16'd32768);
    for (int i = 0; i < 3000; i++) begin
      logic signed [15:0] e;
      logic v;
      string req;
      cfg(1'($urandom % 4 == 0), 1'($urandom), 1'($urandom),
          4'($urandom % ((i % 3 == 0) ? 2 : 16)), 4'($urandom));
      v = ($urandom % 5) != 0;
      if (i % 200 < 60) e = 16'sd30000;
      else if (i % 200 < 100) e = -16'sd30000;
      else e = 16'($urandom);
      if (!v) req = "R8";
      else if (cfg_median) req = "R6";
      else req = "R5";
      step(req, v, e, 1'($urandom));
      if (i % 997 == 500) do_reset(16'($urandom));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule